// File: doc/BRIEF.md
# Slave window decoder with one-way boot remap

This block turns a system-bus address into a one-hot select for one of up to 32 slaves. Each slave has a configuration word that holds the base of its window, a power-of-two window size and an enable bit. A 32-bit register port lets software program those words, store an arbitration priority word and an idle-count word, and read a fixed revision value. The block only stores the priority and idle-count words. Arbitration and idle timing are handled elsewhere.

After boot, software sets the control bit to swap the boot ROM (slave 4) with the RAM (slave 6). The RAM then answers at the address where the ROM used to start, and the ROM moves to the address just past the end of the relocated RAM. Software cannot undo the swap. A reset undoes it, unless the boot-mode input is high during that reset.

Top module: `bus_window_decoder`

## Requirements
- R1: Slave n's configuration word is at byte offset 4*n. Each word resets to the value in parameter SLV_INIT. With the defaults, slave 4 resets to 0x00040001, slave 6 to 0x10060001, and every other slave to 0. A slave other than 4 or 6 reads back exactly what was written.
- R2: Offset 0x80 (priority) and offset 0x84 (idle count) are plain read/write words that reset to 0. Offset 0x8C always reads 0x00010301, and writes to it are ignored without an error.
- R3: In a configuration word, bit 0 enables the window, bits 31:20 give the base in 1 MB units, and bits 19:16 give a size code s for a window of 2^s MB. An address in an enabled window drives that slave's bit of dec_sel in the same cycle.
- R4: When several windows hit, only the lowest-numbered slave is selected. When no window hits, dec_sel is 0 and dec_miss is 1. Otherwise dec_miss is 0.
- R5: A write to the control word at 0x88 with bit 0 set, while not yet remapped, takes effect at that clock edge. From that edge, RAM's base is the ROM's configured base, and ROM's base is that value plus 2^s MB, where s is slave 6's size code. remap_active goes high at the same edge.
- R6: While remapped, a control write with bit 0 clear raises reg_err in that cycle and leaves remap in force.
- R7: The control word reads back the last value written, with bit 0 forced to 1 while remapped.
- R8: Reading slave 4 or slave 6 returns that slave's effective base in bits 31:20 and its stored bits 19:0.
- R9: Reset clears the control word. Reset clears the remap only when boot_keep is low; with boot_keep high the swapped map survives.
- R10: An access with byte enables other than 4'hF, an unaligned offset, or an offset that maps to no register reads 0, changes nothing, and raises reg_err in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_keep | input | 1 | Boot-mode input; when high during reset, the remap is kept |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_be | input | 4 | Byte enables; only 4'hF is valid |
| reg_addr | input | 12 | Byte offset in the register space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| reg_err | output | 1 | Invalid access or attempt to clear the remap |
| dec_addr | input | 32 | Bus address to decode |
| dec_sel | output | NSLV | One-hot slave select |
| dec_miss | output | 1 | No window matched |
| remap_active | output | 1 | ROM/RAM swap is in force |

## Verification
Decode, read data and reg_err are combinational, so they are due in the cycle of the stimulus. The bench drives each input on a falling edge and samples these outputs one nanosecond later, before the next rising edge. Register writes, the remap and reset take effect at the rising edge where they are presented. Every check that depends on them is therefore made after that edge, by reading or decoding in a later cycle. reg_err for a write is sampled during the write cycle, before that edge.

// File: rtl/bus_window_decoder.sv
module bus_window_decoder #(
  parameter int NSLV    = 32,
  parameter int ROM_IDX = 4,
  parameter int RAM_IDX = 6,
  parameter int OFS_W   = 12,
  parameter logic [NSLV*32-1:0] SLV_INIT =
    {{(NSLV-7){32'h0}}, 32'h10060001, 32'h0, 32'h00040001, {4{32'h0}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_keep,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [3:0]       reg_be,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_err,
  input  logic [31:0]      dec_addr,
  output logic [NSLV-1:0]  dec_sel,
  output logic             dec_miss,
  output logic             remap_active
);
  localparam int IW = (NSLV > 1) ? $clog2(NSLV) : 1;
  localparam logic [OFS_W-1:0] PRI_OFS = OFS_W'(12'h080);
  localparam logic [OFS_W-1:0] IDL_OFS = OFS_W'(12'h084);
  localparam logic [OFS_W-1:0] CTL_OFS = OFS_W'(12'h088);
  localparam logic [OFS_W-1:0] REV_OFS = OFS_W'(12'h08C);
  localparam logic [31:0]      REV_VAL = 32'h00010301;

  logic [31:0] cfg [NSLV];
  logic [31:0] pri_q, idle_q, ctl_q;
  logic        remap_q;
  logic [11:0] rom_rm, ram_rm;
  logic [11:0] eff [NSLV];
  logic [NSLV-1:0] hit;

  logic [IW-1:0] slot;
  logic word_ok, slv_ofs, ctl_ofs, acc_ok, we, lock_err;
  logic [11:0] ram_span;

  assign slot     = reg_addr[IW+1:2];
  assign word_ok  = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
  assign slv_ofs  = reg_addr < OFS_W'(NSLV*4);
  assign ctl_ofs  = (reg_addr == PRI_OFS) || (reg_addr == IDL_OFS) ||
                    (reg_addr == CTL_OFS) || (reg_addr == REV_OFS);
  assign acc_ok   = word_ok && (slv_ofs || ctl_ofs);
  assign we       = reg_sel && reg_wr && acc_ok;
  assign lock_err = we && (reg_addr == CTL_OFS) && remap_q && !reg_wdata[0];
  assign reg_err  = (reg_sel && !acc_ok) || lock_err;
  assign ram_span = 12'(1) << cfg[RAM_IDX][19:16];
  assign remap_active = remap_q;

  for (genvar i = 0; i < NSLV; i++) begin : g_win
    logic [16:0] lo, hi, a;
    if (i == ROM_IDX) begin : g_rom
      assign eff[i] = remap_q ? rom_rm : cfg[i][31:20];
    end else if (i == RAM_IDX) begin : g_ram
      assign eff[i] = remap_q ? ram_rm : cfg[i][31:20];
    end else begin : g_std
      assign eff[i] = cfg[i][31:20];
    end
    assign lo     = {5'b0, eff[i]};
    assign hi     = lo + (17'd1 << cfg[i][19:16]);
    assign a      = {5'b0, dec_addr[31:20]};
    assign hit[i] = cfg[i][0] && (a >= lo) && (a < hi);
  end

  assign dec_sel  = hit & (~hit + NSLV'(1));
  assign dec_miss = ~|hit;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_wr && acc_ok) begin
      if (slv_ofs) reg_rdata = {eff[slot], cfg[slot][19:0]};
      else if (reg_addr == PRI_OFS) reg_rdata = pri_q;
      else if (reg_addr == IDL_OFS) reg_rdata = idle_q;
      else if (reg_addr == CTL_OFS) reg_rdata = ctl_q | {31'b0, remap_q};
      else reg_rdata = REV_VAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLV; i++) cfg[i] <= SLV_INIT[i*32 +: 32];
      pri_q  <= '0;
      idle_q <= '0;
      ctl_q  <= '0;
      if (!boot_keep) begin
        remap_q <= 1'b0;
        rom_rm  <= '0;
        ram_rm  <= '0;
      end
    end else if (we) begin
      if (slv_ofs) cfg[slot] <= reg_wdata;
      else if (reg_addr == PRI_OFS) pri_q <= reg_wdata;
      else if (reg_addr == IDL_OFS) idle_q <= reg_wdata;
      else if (reg_addr == CTL_OFS) begin
        ctl_q <= reg_wdata;
        if (!remap_q && reg_wdata[0]) begin
          remap_q <= 1'b1;
          ram_rm  <= cfg[ROM_IDX][31:20];
          rom_rm  <= cfg[ROM_IDX][31:20] + ram_span;
        end
      end
    end
  end
endmodule

module bus_window_decoder_chk #(
  parameter int NSLV  = 32,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [3:0]       reg_be,
  input logic [OFS_W-1:0] reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             reg_err,
  input logic [NSLV-1:0]  dec_sel,
  input logic             dec_miss,
  input logic             remap_active
);
  logic ctl_wr, ctl_rd, rev_rd;
  assign ctl_wr = reg_sel && reg_wr && reg_be == 4'hF && reg_addr == OFS_W'(12'h088);
  assign ctl_rd = reg_sel && !reg_wr && reg_be == 4'hF && reg_addr == OFS_W'(12'h088);
  assign rev_rd = reg_sel && !reg_wr && reg_be == 4'hF && reg_addr == OFS_W'(12'h08C);

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_sel) && (dec_miss == (dec_sel == '0)));
  assert_remap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    remap_active |=> remap_active);
  assert_clear_flags_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && remap_active && !reg_wdata[0]) |-> reg_err);
  assert_ctl_reads_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && remap_active) |-> reg_rdata[0]);
  assert_rev_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rev_rd |-> (reg_rdata == 32'h00010301));
  assert_remap_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remap_active) |-> $past(ctl_wr && reg_wdata[0]));
endmodule

bind bus_window_decoder bus_window_decoder_chk #(.NSLV(NSLV), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_be(reg_be),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_err(reg_err), .dec_sel(dec_sel), .dec_miss(dec_miss),
  .remap_active(remap_active));

// File: tb/sim_bus_window_decoder.sv
module sim_bus_window_decoder;
  localparam int NSLV = 32;

  logic clk = 1'b0, rst_n = 1'b0, boot_keep = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_be = 4'h0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, dec_addr = '0;
  logic reg_err, dec_miss, remap_active;
  logic [NSLV-1:0] dec_sel;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd_v;
  logic err_v;

  always #2 clk = ~clk;

  bus_window_decoder #(.NSLV(NSLV)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_keep(boot_keep), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_be(reg_be), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .dec_addr(dec_addr),
    .dec_sel(dec_sel), .dec_miss(dec_miss), .remap_active(remap_active));

  // {address, expected slave index; 63 = no match}
  localparam logic [37:0] VEC [11] = '{
    {32'h00000000, 6'd4},  {32'h00FFFFFC, 6'd4},  {32'h01000000, 6'd63},
    {32'h00900000, 6'd1},  {32'h00B00000, 6'd1},  {32'h00C00000, 6'd4},
    {32'h10000000, 6'd6},  {32'h13FFFFFF, 6'd6},  {32'h14000000, 6'd63},
    {32'h20080000, 6'd9},  {32'h20100000, 6'd63}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    #1 err_v = reg_err;
    @(posedge clk);
    #1 reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_be = be;
    #1 rd_v = reg_rdata; err_v = reg_err;
    reg_sel = 1'b0;
  endtask

  task automatic dec(input string tag, input logic [31:0] a, input logic [5:0] idx);
    @(negedge clk);
    dec_addr = a;
    #1;
    chk(tag, 32'(dec_sel), (idx == 6'd63) ? 32'h0 : (32'h1 << idx));
    chk(tag, 32'(dec_miss), (idx == 6'd63) ? 32'h1 : 32'h0);
  endtask

  task automatic do_reset(input logic keep);
    @(negedge clk);
    boot_keep = keep; rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; boot_keep = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // reset state
    rd(12'h088, 4'hF); chk("R9 ctl after reset", rd_v, 32'h0);
    rd(12'h010, 4'hF); chk("R1 slave4 init", rd_v, 32'h00040001);
    rd(12'h018, 4'hF); chk("R1 slave6 init", rd_v, 32'h10060001);
    rd(12'h080, 4'hF); chk("R2 priority reset", rd_v, 32'h0);
    rd(12'h08C, 4'hF); chk("R2 revision", rd_v, 32'h00010301);
    chk("R9 remap off", 32'(remap_active), 32'h0);

    // R1: program extra windows
    wr(12'h004, 32'h00820001, 4'hF); chk("R1 write err", 32'(err_v), 32'h0);
    wr(12'h024, 32'h20000001, 4'hF);
    wr(12'h030, 32'h20000001, 4'hF);
    rd(12'h004, 4'hF); chk("R1 slave1 readback", rd_v, 32'h00820001);
    rd(12'h030, 4'hF); chk("R1 slave12 readback", rd_v, 32'h20000001);

    // R3/R4: vector table
    for (int k = 0; k < 11; k++) dec("R3 R4 table decode", VEC[k][37:6], VEC[k][5:0]);

    // R2 storage and read-only revision
    wr(12'h080, 32'hDEAD0001, 4'hF);
    wr(12'h084, 32'h0000ABCD, 4'hF);
    wr(12'h08C, 32'h0, 4'hF); chk("R2 rev write no err", 32'(err_v), 32'h0);
    rd(12'h080, 4'hF); chk("R2 priority", rd_v, 32'hDEAD0001);
    rd(12'h084, 4'hF); chk("R2 idle", rd_v, 32'h0000ABCD);
    rd(12'h08C, 4'hF); chk("R2 rev unchanged", rd_v, 32'h00010301);

    // R10: invalid accesses
    rd(12'h090, 4'hF); chk("R10 undef read data", rd_v, 32'h0);
    chk("R10 undef read err", 32'(err_v), 32'h1);
    rd(12'h080, 4'h3); chk("R10 partial read data", rd_v, 32'h0);
    chk("R10 partial read err", 32'(err_v), 32'h1);
    wr(12'h084, 32'h00000012, 4'h1); chk("R10 partial write err", 32'(err_v), 32'h1);
    wr(12'h086, 32'h00000034, 4'hF); chk("R10 unaligned write err", 32'(err_v), 32'h1);
    wr(12'hFFC, 32'h1, 4'hF); chk("R10 undef write err", 32'(err_v), 32'h1);
    rd(12'h084, 4'hF); chk("R10 idle untouched", rd_v, 32'h0000ABCD);
    rd(12'h088, 4'hF); chk("R10 ctl untouched", rd_v, 32'h0);

    // R5: remap
    wr(12'h088, 32'h00000005, 4'hF); chk("R5 remap write err", 32'(err_v), 32'h0);
    chk("R5 remap active", 32'(remap_active), 32'h1);
    dec("R5 RAM at old ROM base", 32'h00000000, 6'd6);
    dec("R5 RAM top", 32'h03F00000, 6'd6);
    dec("R5 ROM above RAM", 32'h04000000, 6'd4);
    dec("R5 ROM top", 32'h04F00000, 6'd4);
    dec("R5 past ROM", 32'h05000000, 6'd63);
    dec("R5 old RAM base empty", 32'h10000000, 6'd63);
    dec("R4 lower index over RAM", 32'h00900000, 6'd1);
    // R8
    rd(12'h010, 4'hF); chk("R8 slave4 effective", rd_v, 32'h04040001);
    rd(12'h018, 4'hF); chk("R8 slave6 effective", rd_v, 32'h00060001);
    rd(12'h004, 4'hF); chk("R1 slave1 unaffected", rd_v, 32'h00820001);
    // R7 / R6
    rd(12'h088, 4'hF); chk("R7 ctl readback", rd_v, 32'h00000005);
    wr(12'h088, 32'h00000004, 4'hF); chk("R6 clear flags err", 32'(err_v), 32'h1);
    chk("R6 remap kept", 32'(remap_active), 32'h1);
    rd(12'h088, 4'hF); chk("R7 bit0 forced", rd_v, 32'h00000005);
    dec("R6 map unchanged", 32'h00000000, 6'd6);

    // R9: reset in boot mode keeps the swap
    do_reset(1'b1);
    chk("R9 keep remap", 32'(remap_active), 32'h1);
    rd(12'h088, 4'hF); chk("R9 ctl reset, bit0 forced", rd_v, 32'h00000001);
    dec("R9 swapped map kept", 32'h00000000, 6'd6);
    rd(12'h004, 4'hF); chk("R1 slave1 back to init", rd_v, 32'h0);

    // R9: normal reset restores the map
    do_reset(1'b0);
    chk("R9 remap cleared", 32'(remap_active), 32'h0);
    rd(12'h088, 4'hF); chk("R9 ctl zero", rd_v, 32'h0);
    dec("R9 ROM restored", 32'h00000000, 6'd4);
    dec("R9 RAM restored", 32'h10000000, 6'd6);
    rd(12'h010, 4'hF); chk("R8 slave4 configured", rd_v, 32'h00040001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule